// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block owns the command pins of a two-bank synchronous DRAM from reset until the memory is usable, and afterwards keeps the array alive by scheduling periodic auto-refresh. Following reset it holds the bus in no-operation for a settling pause. It then closes both banks with one all-bank precharge. The mode register load and a run of dummy auto-refresh commands follow, in an order chosen by a parameter. Once that sequence is finished it raises a ready flag.

From then on an interval timer asks a host arbiter for the bus once per refresh period (a 64 ms window split over 4096 refreshes, about 15.6 µs each). When the arbiter grants, the block issues one auto-refresh and reports itself busy for the whole refresh cycle time. A request left unanswered for a full further interval sets a sticky error flag. Clock period, pause length, refresh interval and the precharge, mode-load and refresh cycle counts are parameters. Data transfer and row activation for user traffic belong to other blocks.

Top module: `sdr_init_refresh`

## Requirements
- R1: While reset is applied and directly after it, the command is no-operation, clock enable and data mask are high, and ready, ref_req, busy and ovf_err are low. Clock enable and data mask stay high at all times.
- R2: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as follows: no-op 0111, precharge 0010, auto-refresh 0001, mode load 0000. After reset release the block issues only no-op for at least ceil(PAUSE_NS/CLK_PERIOD_NS) cycles, and no more than 4 cycles beyond that. Its first command is a precharge with addr bit 10 high and bank address 0, which selects all banks.
- R3: The next command follows a precharge exactly TRP_CYC cycles later, a mode load exactly TMRD_CYC cycles later, and an auto-refresh exactly TRC_CYC cycles later. Only no-op is issued in between.
- R4: With MODE_FIRST=1 the initialisation order is precharge, mode load, then INIT_REFS auto-refreshes. With MODE_FIRST=0 it is precharge, INIT_REFS auto-refreshes, then mode load.
- R5: During the mode load command, addr carries MODE_VAL and the bank address is 0.
- R6: ready rises exactly one gap (per R3) after the last initialisation command and then stays high.
- R7: ref_req is never high while ready is low. It first rises exactly REFI cycles after ready rises, with REFI = floor(REFI_NS/CLK_PERIOD_NS).
- R8: If ref_gnt is high while ref_req is high and the block is idle, an auto-refresh appears in the next cycle. busy is high for exactly TRC_CYC cycles starting with that command cycle. ref_req stays high until the refresh is issued and is low in the cycle after it.
- R9: After a granted auto-refresh, ref_req rises again exactly REFI cycles after the refresh command cycle.
- R10: ref_gnt has no effect while ref_req is low: the command stays no-op and busy stays low.
- R11: If ref_req has been high without a grant for REFI cycles, ovf_err rises in that cycle. It then stays high until reset, even after the refresh is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Arbiter grant for a pending refresh |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |
| dqm | output | 1 | Data mask / output disable |
| addr | output | ADDR_W | Address bus; bit AP_BIT selects all banks on precharge |
| ba | output | 1 | Bank address |
| ready | output | 1 | Initialisation complete |
| ref_req | output | 1 | Refresh request to the arbiter |
| busy | output | 1 | Refresh cycle in progress |
| ovf_err | output | 1 | Sticky flag: a refresh request went unanswered for a full interval |

## Verification
The hardest state to reach from the ports is the refresh overflow. It requires a request that is already pending to meet a second timer expiry, and only an arbiter that deliberately withholds its grant can produce that. The bench first serves one refresh normally, which proves the reload point. It then leaves the next request ungranted and watches the flag cycle by cycle across the full interval. Finally it grants late, to show that the flag survives the refresh and clears only on reset. A second instance built with the opposite order parameter covers the other initialisation order in the same run.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;
  typedef enum logic [2:0] {
    ST_PAUSE, ST_PRE, ST_MRS, ST_AREF, ST_GAP, ST_IDLE, ST_RREF, ST_RGAP
  } seq_st_t;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;
endpackage

// File: rtl/sdr_init_seq.sv
module sdr_init_seq
  import sdr_seq_pkg::*;
#(
  parameter int PAUSE_CYC  = 20000,
  parameter int TRP_CYC    = 3,
  parameter int TMRD_CYC   = 2,
  parameter int TRC_CYC    = 9,
  parameter int INIT_REFS  = 8,
  parameter bit MODE_FIRST = 1'b1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ref_take,
  output seq_st_t st
);
  localparam int GAP_MAX = (TRC_CYC > TRP_CYC) ? ((TRC_CYC > TMRD_CYC) ? TRC_CYC : TMRD_CYC)
                                               : ((TRP_CYC > TMRD_CYC) ? TRP_CYC : TMRD_CYC);
  localparam int CNT_MAX = (PAUSE_CYC > GAP_MAX) ? PAUSE_CYC : GAP_MAX;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int NW      = $clog2(INIT_REFS + 1);

  seq_st_t         st_q, st_d, after_gap;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [NW-1:0]   nref_q, nref_d;
  logic            mrs_q, mrs_d;

  always_comb begin
    if (!mrs_q && (MODE_FIRST || nref_q == NW'(INIT_REFS))) after_gap = ST_MRS;
    else if (nref_q != NW'(INIT_REFS))                         after_gap = ST_AREF;
    else                                                       after_gap = ST_IDLE;
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    nref_d = nref_q;
    mrs_d  = mrs_q;
    case (st_q)
      ST_PAUSE: if (cnt_q == CW'(PAUSE_CYC)) st_d = ST_PRE;
                else                         cnt_d = cnt_q + 1'b1;
      ST_PRE:   begin st_d = ST_GAP; cnt_d = CW'(TRP_CYC - 2); end
      ST_MRS:   begin st_d = ST_GAP; cnt_d = CW'(TMRD_CYC - 2); mrs_d = 1'b1; end
      ST_AREF:  begin st_d = ST_GAP; cnt_d = CW'(TRC_CYC - 2); nref_d = nref_q + 1'b1; end
      ST_GAP:   if (cnt_q == '0) st_d = after_gap;
                else             cnt_d = cnt_q - 1'b1;
      ST_IDLE:  if (ref_take) st_d = ST_RREF;
      ST_RREF:  begin st_d = ST_RGAP; cnt_d = CW'(TRC_CYC - 2); end
      ST_RGAP:  if (cnt_q == '0) st_d = ST_IDLE;
                else             cnt_d = cnt_q - 1'b1;
      default:  st_d = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_PAUSE;
      cnt_q  <= '0;
      nref_q <= '0;
      mrs_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      nref_q <= nref_d;
      mrs_q  <= mrs_d;
    end
  end

  assign st = st_q;

  // R4
  nref_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_AREF) |-> (nref_q < NW'(INIT_REFS)));

  // R3
  gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GAP || st_q == ST_RGAP) |-> (cnt_q <= CW'(GAP_MAX)));
endmodule

// File: rtl/sdr_refi_timer.sv
module sdr_refi_timer #(
  parameter int REFI_CYC = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ready,
  input  logic issue,
  output logic req,
  output logic ovf
);
  localparam int RW = $clog2(REFI_CYC + 1);

  logic [RW-1:0] cnt_q, cnt_d;
  logic          req_q, req_d, ovf_q, ovf_d;

  always_comb begin
    cnt_d = cnt_q;
    req_d = req_q;
    ovf_d = ovf_q;
    if (!ready) begin
      cnt_d = RW'(REFI_CYC - 1);
      req_d = 1'b0;
    end else if (issue) begin
      cnt_d = RW'(REFI_CYC - 2);
      req_d = 1'b0;
    end else if (cnt_q == '0) begin
      cnt_d = RW'(REFI_CYC - 1);
      req_d = 1'b1;
      if (req_q) ovf_d = 1'b1;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RW'(REFI_CYC - 1);
      req_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
      ovf_q <= ovf_d;
    end
  end

  assign req = req_q;
  assign ovf = ovf_q;

  // R11
  ovf_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(req_q));
endmodule

// File: rtl/sdr_cmd_enc.sv
module sdr_cmd_enc
  import sdr_seq_pkg::*;
#(
  parameter int              ADDR_W   = 11,
  parameter int              AP_BIT   = 10,
  parameter logic [ADDR_W-1:0] MODE_VAL = 'h032
) (
  input  seq_st_t           st,
  output logic [3:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic              ba
);
  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    ba   = 1'b0;
    case (st)
      ST_PRE:           begin cmd = CMD_PRE; addr[AP_BIT] = 1'b1; end
      ST_MRS:           begin cmd = CMD_MRS; addr = MODE_VAL; end
      ST_AREF, ST_RREF: cmd = CMD_REF;
      default:          cmd = CMD_NOP;
    endcase
  end
endmodule

// File: rtl/sdr_init_refresh.sv
module sdr_init_refresh
  import sdr_seq_pkg::*;
#(
  parameter int                CLK_PERIOD_NS = 10,
  parameter int                PAUSE_NS      = 200000,
  parameter int                REFI_NS       = 15600,
  parameter int                TRP_CYC       = 3,
  parameter int                TMRD_CYC      = 2,
  parameter int                TRC_CYC       = 9,
  parameter int                INIT_REFS     = 8,
  parameter bit                MODE_FIRST    = 1'b1,
  parameter int                ADDR_W        = 11,
  parameter int                AP_BIT        = 10,
  parameter logic [ADDR_W-1:0] MODE_VAL      = 'h032
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_gnt,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              cke,
  output logic              dqm,
  output logic [ADDR_W-1:0] addr,
  output logic              ba,
  output logic              ready,
  output logic              ref_req,
  output logic              busy,
  output logic              ovf_err
);
  localparam int PAUSE_CYC = (PAUSE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int REFI_CYC  = REFI_NS / CLK_PERIOD_NS;

  logic [1:0] rst_sync;
  logic       rst_s;
  seq_st_t    st;
  logic [3:0] cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  sdr_init_seq #(
    .PAUSE_CYC(PAUSE_CYC), .TRP_CYC(TRP_CYC), .TMRD_CYC(TMRD_CYC),
    .TRC_CYC(TRC_CYC), .INIT_REFS(INIT_REFS), .MODE_FIRST(MODE_FIRST)
  ) u_seq (
    .clk(clk), .rst_n(rst_s), .ref_take(ref_req & ref_gnt), .st(st)
  );

  sdr_refi_timer #(.REFI_CYC(REFI_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_s), .ready(ready), .issue(st == ST_RREF),
    .req(ref_req), .ovf(ovf_err)
  );

  sdr_cmd_enc #(.ADDR_W(ADDR_W), .AP_BIT(AP_BIT), .MODE_VAL(MODE_VAL)) u_enc (
    .st(st), .cmd(cmd), .addr(addr), .ba(ba)
  );

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign cke   = 1'b1;
  assign dqm   = 1'b1;
  assign ready = (st == ST_IDLE) || (st == ST_RREF) || (st == ST_RGAP);
  assign busy  = (st == ST_RREF) || (st == ST_RGAP);

  // R7
  req_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ref_req |-> ready);

  // R6
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ready |=> ready);

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ovf_err |=> ovf_err);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (ref_req && cmd != CMD_REF) |=> ref_req);

  // R8
  busy_on_ref_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (ready && cmd == CMD_REF) |-> busy);

  // R3
  nop_after_ref_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (cmd == CMD_REF) |=> (cmd == CMD_NOP));
endmodule

// File: tb/tb_sdr_init_refresh.sv
module tb_sdr_init_refresh;
  localparam int CLK_NS = 4;
  localparam int PAUSE  = 100;
  localparam int REFI   = 60;
  localparam int TRP    = 3;
  localparam int TMRD   = 2;
  localparam int TRC    = 6;
  localparam int NREF   = 8;
  localparam logic [10:0] MV = 11'h032;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  logic clk = 1'b0;
  logic rst_n, gnt;
  logic cs_n, ras_n, cas_n, we_n, cke, dqm, ba, ready, ref_req, busy, ovf_err;
  logic [10:0] addr;
  logic a_cs_n, a_ras_n, a_cas_n, a_we_n, a_cke, a_dqm, a_ba, a_ready, a_req, a_busy, a_ovf;
  logic [10:0] a_addr;

  int total = 0, bad = 0, cyc = 0;
  int bad_req = 0, low_ctl = 0;
  int rel_cyc, rdy_m, rdy_a, aref_cyc, q_cyc;
  int tm[16], ta[16];
  logic [3:0]  cm[16], ca[16];
  logic [10:0] am[16];
  logic        bm[16];
  int nm, na;

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdr_init_refresh #(.CLK_PERIOD_NS(CLK_NS), .PAUSE_NS(PAUSE*CLK_NS), .REFI_NS(REFI*CLK_NS),
    .TRP_CYC(TRP), .TMRD_CYC(TMRD), .TRC_CYC(TRC), .INIT_REFS(NREF), .MODE_FIRST(1'b1),
    .ADDR_W(11), .AP_BIT(10), .MODE_VAL(MV)) dut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(gnt), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .dqm(dqm), .addr(addr), .ba(ba), .ready(ready),
    .ref_req(ref_req), .busy(busy), .ovf_err(ovf_err));

  sdr_init_refresh #(.CLK_PERIOD_NS(CLK_NS), .PAUSE_NS(PAUSE*CLK_NS), .REFI_NS(REFI*CLK_NS),
    .TRP_CYC(TRP), .TMRD_CYC(TMRD), .TRC_CYC(TRC), .INIT_REFS(NREF), .MODE_FIRST(1'b0),
    .ADDR_W(11), .AP_BIT(10), .MODE_VAL(MV)) dut_alt (
    .clk(clk), .rst_n(rst_n), .ref_gnt(1'b0), .cs_n(a_cs_n), .ras_n(a_ras_n), .cas_n(a_cas_n),
    .we_n(a_we_n), .cke(a_cke), .dqm(a_dqm), .addr(a_addr), .ba(a_ba), .ready(a_ready),
    .ref_req(a_req), .busy(a_busy), .ovf_err(a_ovf));

  wire [3:0] cmd   = {cs_n, ras_n, cas_n, we_n};
  wire [3:0] a_cmd = {a_cs_n, a_ras_n, a_cas_n, a_we_n};

  always @(negedge clk) begin
    if (ref_req && !ready) bad_req++;
    if (!cke || !dqm || !a_cke || !a_dqm) low_ctl++;
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  task automatic t_reset();
    gnt = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(cmd == NOP, "R1 cmd in reset", cmd, NOP);
    chk(cke && dqm, "R1 cke/dqm in reset", {cke, dqm}, 3);
    chk({ready, ref_req, busy, ovf_err} == 4'b0, "R1 flags in reset",
        {ready, ref_req, busy, ovf_err}, 0);
    rst_n = 1'b1;
    rel_cyc = cyc;
    @(negedge clk);
    chk(cmd == NOP && !ready && !ovf_err, "R1 after release", {cmd, ready, ovf_err}, {NOP, 2'b00});
  endtask

  task automatic t_init();
    bit dm = 0, da = 0;
    nm = 0; na = 0;
    while (!(dm && da)) begin
      @(negedge clk);
      if (!dm) begin
        if (ready) begin dm = 1; rdy_m = cyc; end
        else if (cmd != NOP && nm < 16) begin
          tm[nm] = cyc; cm[nm] = cmd; am[nm] = addr; bm[nm] = ba; nm++;
        end
      end
      if (!da) begin
        if (a_ready) begin da = 1; rdy_a = cyc; end
        else if (a_cmd != NOP && na < 16) begin
          ta[na] = cyc; ca[na] = a_cmd; na++;
        end
      end
    end
    chk(nm == NREF + 2, "R4 main command count", nm, NREF + 2);
    chk(cm[0] == PRE, "R2 first command precharge", cm[0], PRE);
    chk(am[0][10] == 1'b1 && bm[0] == 1'b0, "R2 all-bank select", {am[0][10], bm[0]}, 2);
    chk(tm[0] - rel_cyc >= PAUSE && tm[0] - rel_cyc <= PAUSE + 4, "R2 pause length",
        tm[0] - rel_cyc, PAUSE);
    chk(cm[1] == MRS, "R4 mode load second", cm[1], MRS);
    chk(am[1] == MV && bm[1] == 1'b0, "R5 mode value", am[1], MV);
    chk(tm[1] - tm[0] == TRP, "R3 precharge gap", tm[1] - tm[0], TRP);
    chk(tm[2] - tm[1] == TMRD, "R3 mode load gap", tm[2] - tm[1], TMRD);
    for (int k = 2; k < NREF + 2; k++) begin
      chk(cm[k] == REF, "R4 dummy refresh", cm[k], REF);
      if (k < NREF + 1) chk(tm[k+1] - tm[k] == TRC, "R3 refresh gap", tm[k+1] - tm[k], TRC);
    end
    chk(rdy_m - tm[NREF+1] == TRC, "R6 ready timing main", rdy_m - tm[NREF+1], TRC);
    chk(na == NREF + 2, "R4 alt command count", na, NREF + 2);
    chk(ca[0] == PRE && ca[1] == REF, "R4 alt order start", {ca[0], ca[1]}, {PRE, REF});
    chk(ca[NREF] == REF && ca[NREF+1] == MRS, "R4 alt mode load last", ca[NREF+1], MRS);
    chk(ta[NREF+1] - ta[NREF] == TRC, "R3 alt refresh to mode gap", ta[NREF+1] - ta[NREF], TRC);
    chk(rdy_a - ta[NREF+1] == TMRD, "R6 ready timing alt", rdy_a - ta[NREF+1], TMRD);
  endtask

  task automatic t_first_req();
    while (!ref_req) @(negedge clk);
    chk(cyc - rdy_m == REFI, "R7 first request delay", cyc - rdy_m, REFI);
    chk(bad_req == 0, "R7 request before ready", bad_req, 0);
    chk(ready, "R6 ready held", ready, 1);
  endtask

  task automatic t_grant();
    int nb;
    gnt = 1'b1;
    @(negedge clk);
    chk(cmd == REF, "R8 refresh after grant", cmd, REF);
    chk(busy, "R8 busy on refresh", busy, 1);
    aref_cyc = cyc;
    gnt = 1'b0;
    nb = 1;
    @(negedge clk);
    chk(!ref_req, "R8 request dropped", ref_req, 0);
    while (busy) begin nb++; @(negedge clk); end
    chk(nb == TRC, "R8 busy length", nb, TRC);
  endtask

  task automatic t_spurious();
    gnt = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(cmd == NOP && !busy, "R10 grant without request", {cmd, busy}, {NOP, 1'b0});
    end
    gnt = 1'b0;
    while (!ref_req) @(negedge clk);
    chk(cyc - aref_cyc == REFI, "R9 request after refresh", cyc - aref_cyc, REFI);
  endtask

  task automatic t_ovf();
    q_cyc = cyc;
    repeat (REFI - 1) @(negedge clk);
    chk(!ovf_err, "R11 no early overflow", ovf_err, 0);
    @(negedge clk);
    chk(ovf_err, "R11 overflow set", ovf_err, 1);
    gnt = 1'b1;
    @(negedge clk);
    chk(cmd == REF, "R8 late grant served", cmd, REF);
    gnt = 1'b0;
    repeat (TRC + 2) @(negedge clk);
    chk(ovf_err, "R11 overflow sticky", ovf_err, 1);
    chk(low_ctl == 0, "R1 cke/dqm always high", low_ctl, 0);
    t_reset();
    chk(!ovf_err, "R11 cleared by reset", ovf_err, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_init();
    t_first_req();
    t_grant();
    t_spurious();
    t_ovf();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule